// File: doc/BRIEF.md
# Dual-Bank Flash Command Decoder

This block is the command front end of a two-bank NOR flash. Each write strobe, a single-cycle `we` pulse, hands it one byte and an address. Some commands take effect at once: read-mode selection, status clearing, suspend and resume. Others need a second write. That second write is either a data write that carries the address and data, or a confirm byte (D0h) that commits the operation. The block picks what a read returns: array data, the status register or the identifier bytes. It starts a behavioural write engine whose busy time is a parameter.

The engine stands in for the real program and transfer algorithms. It works on one bank at a time. While it runs, a read of that bank returns the status register, and a read of the other bank still returns array data. A small page buffer keeps one valid flag per word. The flags are set by single loads and by a transfer from the array. A clear command empties them.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, the status register reads 80h, the engine is idle and every page-buffer valid flag is 0.
- R2: A write of FFh in the idle state, or in the confirm slot of a F1h, 0Eh or 55h sequence, selects array-read mode and sets no error bit. After 40h or 74h the next write is data, even when it is FFh.
- R3: 90h selects identifier mode. A read with rd_addr bit 0 = 0 returns the maker code (default 1Ch), and bit 0 = 1 returns the device code (default A0h).
- R4: 70h selects status mode. The status byte is {ready, suspended, sequence error, lock error, 0000}. Ready (bit 7) is 1 exactly when the engine is not running.
- R5: 40h followed by a data write starts the engine. It runs for BUSY_CYC clock cycles, counted from the edge of the data write. busy_bank shows address bit AW-1 of that write and stays constant while the engine runs.
- R6: While the engine runs, a read whose address bit AW-1 equals busy_bank returns the status byte whatever the read mode. A read of the other bank follows the read mode.
- R7: After F1h, 0Eh or 55h, any second byte other than D0h or FFh sets status bit 5, returns to the idle state and selects status mode.
- R8: 50h clears status bits 5 and 4 and leaves the read mode unchanged.
- R9: A program (40h + data) or page program (0Eh + D0h) to an address below BOOT_LIMIT, while rp_n and wp_n are not both 1, sets status bit 4 and does not start the engine. Addresses at or above BOOT_LIMIT are never locked.
- R10: 74h followed by a write sets the page-buffer valid flag indexed by the low address bits and does not start the engine. 55h followed by D0h clears all flags.
- R11: F1h followed by D0h runs the engine. When it completes, every page-buffer valid flag is 1.
- R12: 0Eh followed by D0h on an unlocked address starts the engine, with busy_bank taken from that address.
- R13: B0h while the engine runs suspends it: status reads C0h and eng_busy drops. A later D0h resumes it. It then finishes after the cycles it still had left.
- R14: The setup bytes 40h, 74h, F1h, 0Eh and 55h are ignored while the engine is running or suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Command or data byte |
| rp_n | input | 1 | Reset-protect level, low locks the boot region |
| wp_n | input | 1 | Write-protect level, low locks the boot region |
| rd_addr | input | AW | Read address |
| array_rdata | input | 8 | Array data for rd_addr |
| rd_data | output | 8 | Read result |
| status | output | 8 | Status byte |
| eng_busy | output | 1 | Engine running |
| busy_bank | output | 1 | Bank owned by the engine |
| pbuf_valid | output | PB_WORDS | Page-buffer valid flags |

## Verification
The hardest state to reach from the ports is a suspend followed by a resume, where the operation must finish exactly on the cycle that its remaining count predicts. The stimulus starts a program, issues B0h a known number of edges later, reads the frozen C0h status, and then resumes. The bench then counts negative edges and checks that the engine is still busy one cycle before its expected end and idle on the cycle of that end. A table of write/read vectors covers the confirm-slot errors and the mode changes.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int CMD_W = 8;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_CLR_SR  = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_LOAD    = 8'h74;
  localparam logic [7:0] CMD_FILL    = 8'hF1;
  localparam logic [7:0] CMD_PAGE    = 8'h0E;
  localparam logic [7:0] CMD_CLR_PB  = 8'h55;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_LOAD, ST_FILL, ST_PAGE, ST_CLRPB
  } seq_e;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT} rmode_e;

  typedef enum logic [1:0] {OP_WORD, OP_FILL, OP_PAGE} op_e;
endpackage

// File: rtl/fcc_engine_stub.sv
module fcc_engine_stub #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_bank,
  input  logic suspend,
  input  logic resume,
  output logic busy,
  output logic susp,
  output logic bank,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic run_q, run_n, susp_q, susp_n, bank_q, bank_n;

  always_comb begin
    cnt_n  = cnt_q;
    run_n  = run_q;
    susp_n = susp_q;
    bank_n = bank_q;
    done   = 1'b0;
    if (start) begin
      cnt_n  = CW'(BUSY_CYC);
      run_n  = 1'b1;
      susp_n = 1'b0;
      bank_n = start_bank;
    end else if (run_q && suspend) begin
      run_n  = 1'b0;
      susp_n = 1'b1;
    end else if (susp_q && resume) begin
      run_n  = 1'b1;
      susp_n = 1'b0;
    end else if (run_q) begin
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_n = 1'b0;
        done  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      susp_q <= 1'b0;
      bank_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      susp_q <= susp_n;
      bank_q <= bank_n;
    end
  end

  assign busy = run_q;
  assign susp = susp_q;
  assign bank = bank_q;
endmodule

// File: rtl/fcc_decoder.sv
module fcc_decoder
  import fcc_pkg::*;
#(
  parameter int AW         = 8,
  parameter int PB_WORDS   = 4,
  parameter int BOOT_LIMIT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       wr_addr,
  input  logic [CMD_W-1:0]    wr_data,
  input  logic                rp_n,
  input  logic                wp_n,
  input  logic                eng_busy,
  input  logic                eng_susp,
  input  logic                eng_done,
  output logic                start,
  output logic                suspend,
  output logic                resume,
  output rmode_e              rmode,
  output logic [CMD_W-1:0]    status,
  output logic [PB_WORDS-1:0] pbuf_valid
);
  localparam int PBW = $clog2(PB_WORDS);

  seq_e   st_q, st_n;
  rmode_e rm_q, rm_n;
  op_e    op_q, op_n;
  logic   seq_err_q, seq_err_n, lock_err_q, lock_err_n;
  logic [PB_WORDS-1:0] pb_q, pb_n;
  logic   locked, eng_idle;

  assign locked   = (wr_addr < AW'(BOOT_LIMIT)) && !(rp_n && wp_n);
  assign eng_idle = !eng_busy && !eng_susp;

  always_comb begin
    st_n       = st_q;
    rm_n       = rm_q;
    op_n       = op_q;
    seq_err_n  = seq_err_q;
    lock_err_n = lock_err_q;
    pb_n       = pb_q;
    start      = 1'b0;
    suspend    = 1'b0;
    resume     = 1'b0;
    if (eng_done && op_q == OP_FILL) pb_n = '1;
    if (we) begin
      unique case (st_q)
        ST_IDLE: begin
          unique case (wr_data)
            CMD_ARRAY:  rm_n = RM_ARRAY;
            CMD_STATUS: rm_n = RM_STATUS;
            CMD_IDENT:  rm_n = RM_IDENT;
            CMD_CLR_SR: begin
              seq_err_n  = 1'b0;
              lock_err_n = 1'b0;
            end
            CMD_SUSPEND: if (eng_busy) begin
              suspend = 1'b1;
              rm_n    = RM_STATUS;
            end
            CMD_CONFIRM: if (eng_susp) begin
              resume = 1'b1;
              rm_n   = RM_STATUS;
            end
            CMD_PROG:   if (eng_idle) begin st_n = ST_PROG;  rm_n = RM_STATUS; end
            CMD_LOAD:   if (eng_idle) begin st_n = ST_LOAD;  rm_n = RM_STATUS; end
            CMD_FILL:   if (eng_idle) begin st_n = ST_FILL;  rm_n = RM_STATUS; end
            CMD_PAGE:   if (eng_idle) begin st_n = ST_PAGE;  rm_n = RM_STATUS; end
            CMD_CLR_PB: if (eng_idle) begin st_n = ST_CLRPB; rm_n = RM_STATUS; end
            default: ;
          endcase
        end
        ST_PROG: begin
          st_n = ST_IDLE;
          if (locked) lock_err_n = 1'b1;
          else begin
            start = 1'b1;
            op_n  = OP_WORD;
          end
        end
        ST_LOAD: begin
          st_n = ST_IDLE;
          pb_n[wr_addr[PBW-1:0]] = 1'b1;
        end
        default: begin
          st_n = ST_IDLE;
          if (wr_data == CMD_ARRAY) rm_n = RM_ARRAY;
          else if (wr_data != CMD_CONFIRM) begin
            seq_err_n = 1'b1;
            rm_n      = RM_STATUS;
          end else begin
            unique case (st_q)
              ST_FILL: begin
                start = 1'b1;
                op_n  = OP_FILL;
              end
              ST_PAGE: begin
                if (locked) lock_err_n = 1'b1;
                else begin
                  start = 1'b1;
                  op_n  = OP_PAGE;
                end
              end
              default: pb_n = '0;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      rm_q       <= RM_ARRAY;
      op_q       <= OP_WORD;
      seq_err_q  <= 1'b0;
      lock_err_q <= 1'b0;
      pb_q       <= '0;
    end else begin
      st_q       <= st_n;
      rm_q       <= rm_n;
      op_q       <= op_n;
      seq_err_q  <= seq_err_n;
      lock_err_q <= lock_err_n;
      pb_q       <= pb_n;
    end
  end

  assign rmode      = rm_q;
  assign status     = {!eng_busy, eng_susp, seq_err_q, lock_err_q, 4'b0000};
  assign pbuf_valid = pb_q;
endmodule

// File: rtl/fcc_read_sel.sv
module fcc_read_sel
  import fcc_pkg::*;
#(
  parameter int          AW     = 8,
  parameter logic [7:0]  MFR_ID = 8'h1C,
  parameter logic [7:0]  DEV_ID = 8'hA0
) (
  input  rmode_e           rmode,
  input  logic [AW-1:0]    rd_addr,
  input  logic [CMD_W-1:0] array_rdata,
  input  logic [CMD_W-1:0] status,
  input  logic             eng_busy,
  input  logic             busy_bank,
  output logic [CMD_W-1:0] rd_data
);
  always_comb begin
    if (eng_busy && rd_addr[AW-1] == busy_bank) rd_data = status;
    else begin
      unique case (rmode)
        RM_STATUS: rd_data = status;
        RM_IDENT:  rd_data = rd_addr[0] ? DEV_ID : MFR_ID;
        default:   rd_data = array_rdata;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int         AW         = 8,
  parameter int         PB_WORDS   = 4,
  parameter int         BOOT_LIMIT = 16,
  parameter int         BUSY_CYC   = 8,
  parameter logic [7:0] MFR_ID     = 8'h1C,
  parameter logic [7:0] DEV_ID     = 8'hA0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                rp_n,
  input  logic                wp_n,
  input  logic [AW-1:0]       rd_addr,
  input  logic [7:0]          array_rdata,
  output logic [7:0]          rd_data,
  output logic [7:0]          status,
  output logic                eng_busy,
  output logic                busy_bank,
  output logic [PB_WORDS-1:0] pbuf_valid
);
  logic   start, suspend, resume, eng_susp, eng_done;
  rmode_e rmode;

  fcc_decoder #(.AW(AW), .PB_WORDS(PB_WORDS), .BOOT_LIMIT(BOOT_LIMIT)) u_dec (
    .clk(clk), .rst_n(rst_n), .we(we), .wr_addr(wr_addr), .wr_data(wr_data),
    .rp_n(rp_n), .wp_n(wp_n), .eng_busy(eng_busy), .eng_susp(eng_susp),
    .eng_done(eng_done), .start(start), .suspend(suspend), .resume(resume),
    .rmode(rmode), .status(status), .pbuf_valid(pbuf_valid)
  );

  fcc_engine_stub #(.BUSY_CYC(BUSY_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .start_bank(wr_addr[AW-1]),
    .suspend(suspend), .resume(resume), .busy(eng_busy), .susp(eng_susp),
    .bank(busy_bank), .done(eng_done)
  );

  fcc_read_sel #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .rmode(rmode), .rd_addr(rd_addr), .array_rdata(array_rdata),
    .status(status), .eng_busy(eng_busy), .busy_bank(busy_bank),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int AW       = 8,
  parameter int PB_WORDS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                we,
  input logic [AW-1:0]       rd_addr,
  input logic [7:0]          rd_data,
  input logic [7:0]          status,
  input logic                eng_busy,
  input logic                busy_bank,
  input logic [PB_WORDS-1:0] pbuf_valid
);
  AST_BUSY_BANK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && rd_addr[AW-1] == busy_bank) |-> rd_data == status); // R6
  AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(we)); // R5
  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy)) |-> $stable(busy_bank)); // R5
  AST_SUSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_busy && status[6])); // R13
  AST_LOCK_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> !eng_busy); // R9
  AST_PBUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy)) |-> $stable(pbuf_valid)); // R14
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.AW(AW), .PB_WORDS(PB_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .rd_addr(rd_addr), .rd_data(rd_data),
  .status(status), .eng_busy(eng_busy), .busy_bank(busy_bank),
  .pbuf_valid(pbuf_valid)
);

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;
  localparam int AW = 8;
  localparam int PBN = 4;

  logic clk = 1'b0;
  logic rst_n, we, rp_n, wp_n;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, array_rdata, rd_data, status;
  logic eng_busy, busy_bank;
  logic [PBN-1:0] pbuf_valid;
  int total = 0, bad = 0;

  always #2 clk = ~clk;
  assign array_rdata = rd_addr ^ 8'h5A;

  flash_cmd_ctrl #(.AW(AW), .PB_WORDS(PBN), .BOOT_LIMIT(16), .BUSY_CYC(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .we(we), .wr_addr(wr_addr), .wr_data(wr_data),
    .rp_n(rp_n), .wp_n(wp_n), .rd_addr(rd_addr), .array_rdata(array_rdata),
    .rd_data(rd_data), .status(status), .eng_busy(eng_busy),
    .busy_bank(busy_bank), .pbuf_valid(pbuf_valid)
  );

  // {wr_addr, wr_data, rd_addr, expected rd_data}
  localparam logic [31:0] VEC [15] = '{
    32'h00_90_00_1C, 32'h00_90_01_A0, 32'h00_FF_05_5F, 32'h00_70_05_80,
    32'h00_F1_05_80, 32'h10_33_05_A0, 32'h00_50_05_80, 32'h00_0E_05_80,
    32'h00_FF_85_DF, 32'h00_70_85_80, 32'h00_55_00_80, 32'h00_12_00_A0,
    32'h00_FF_00_5A, 32'h00_50_00_5A, 32'h00_70_00_80
  };
  localparam string VTAG [15] = '{
    "R3", "R3", "R2", "R4", "R7", "R7", "R8", "R12",
    "R2", "R2", "R10", "R7", "R2", "R8", "R8"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    rd_addr = a;
    #0.5;
    chk(tag, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && eng_busy; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; rp_n = 1'b1; wp_n = 1'b1;
    wr_addr = '0; wr_data = '0; rd_addr = 8'h07;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", {24'h0, status}, 32'h80);
    chk("R1 busy", {31'h0, eng_busy}, 32'h0);
    chk("R1 pbuf", {28'h0, pbuf_valid}, 32'h0);
    rd_chk("R1 array", 8'h07, 8'h5D);

    for (int i = 0; i < 15; i++) begin
      wr(VEC[i][31:24], VEC[i][23:16]);
      rd_chk(VTAG[i], VEC[i][15:8], VEC[i][7:0]);
    end

    // R10 single loads, then clear
    wr(8'h00, 8'h74); wr(8'h02, 8'h11);
    chk("R10 load", {28'h0, pbuf_valid}, 32'h4);
    chk("R10 no start", {31'h0, eng_busy}, 32'h0);
    wr(8'h00, 8'h74); wr(8'h03, 8'hFF);
    chk("R2 data slot", {28'h0, pbuf_valid}, 32'hC);
    wr(8'h00, 8'h55); wr(8'h00, 8'hD0);
    chk("R10 clear", {28'h0, pbuf_valid}, 32'h0);

    // R5 / R6 program in bank 1
    wr(8'h00, 8'h40); wr(8'h90, 8'h77);
    chk("R5 busy", {31'h0, eng_busy}, 32'h1);
    chk("R5 bank", {31'h0, busy_bank}, 32'h1);
    chk("R4 ready low", {24'h0, status}, 32'h00);
    wr(8'h00, 8'hFF);
    rd_chk("R6 busy bank", 8'h85, 8'h00);
    rd_chk("R6 other bank", 8'h05, 8'h5F);
    repeat (5) @(negedge clk);
    chk("R5 last busy cycle", {31'h0, eng_busy}, 32'h1);
    @(negedge clk);
    chk("R5 done", {31'h0, eng_busy}, 32'h0);
    rd_chk("R6 after", 8'h85, 8'hDF);

    // R14 setup ignored while running
    wr(8'h00, 8'h40); wr(8'h90, 8'h77);
    wr(8'h00, 8'h74); wr(8'h02, 8'h33);
    chk("R14 ignored", {28'h0, pbuf_valid}, 32'h0);
    wait_idle();

    // R13 suspend and resume
    wr(8'h00, 8'h40); wr(8'h20, 8'h01);
    wr(8'h00, 8'hB0);
    chk("R13 suspended", {24'h0, status}, 32'hC0);
    chk("R13 not busy", {31'h0, eng_busy}, 32'h0);
    wr(8'h00, 8'h74); wr(8'h01, 8'h44);
    chk("R14 ignored susp", {28'h0, pbuf_valid}, 32'h0);
    wr(8'h00, 8'hD0);
    chk("R13 resumed", {31'h0, eng_busy}, 32'h1);
    repeat (6) @(negedge clk);
    chk("R13 remaining", {31'h0, eng_busy}, 32'h1);
    @(negedge clk);
    chk("R13 finish", {24'h0, status}, 32'h80);

    // R11 array to page buffer
    wr(8'h00, 8'hF1); wr(8'h00, 8'hD0);
    chk("R11 busy", {31'h0, eng_busy}, 32'h1);
    wait_idle();
    chk("R11 filled", {28'h0, pbuf_valid}, 32'hF);

    // R12 page program
    wr(8'h00, 8'h0E); wr(8'h80, 8'hD0);
    chk("R12 busy", {31'h0, eng_busy}, 32'h1);
    chk("R12 bank", {31'h0, busy_bank}, 32'h1);
    wait_idle();

    // R9 locking
    wp_n = 1'b0;
    wr(8'h00, 8'h40); wr(8'h03, 8'h55);
    chk("R9 lock prog", {24'h0, status}, 32'h90);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h0E); wr(8'h00, 8'hD0);
    chk("R9 lock page", {24'h0, status}, 32'h90);
    chk("R9 no run", {31'h0, eng_busy}, 32'h0);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h40); wr(8'h20, 8'h55);
    chk("R9 outside boot", {31'h0, eng_busy}, 32'h1);
    wait_idle();
    wp_n = 1'b1; rp_n = 1'b0;
    wr(8'h00, 8'h40); wr(8'h01, 8'h55);
    chk("R9 rp lock", {24'h0, status}, 32'h90);
    rp_n = 1'b1;
    wr(8'h00, 8'h40); wr(8'h01, 8'h55);
    chk("R9 unlocked", {31'h0, eng_busy}, 32'h1);
    wait_idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule